// File: doc/BRIEF.md
# Serial Interrupt Bus Peripheral Agent

This block is the peripheral end of a single-wire serialized interrupt bus. It runs on the bus clock and samples the shared line on every rising edge. The line idles high through a pull-up. The host opens each cycle with a long low pulse. A fixed run of three-clock slots follows, one slot per interrupt number. A short low pulse closes the cycle, and its width tells every agent how the next cycle may begin. The agent reports each local interrupt level in its own slot. It does this through a pair of outputs that an I/O cell turns into drive-low, drive-high or release.

The agent learns the bus mode from the width of the closing pulse. In continuous mode only the host opens cycles. In quiet mode the agent may pull the line low for one clock to ask the host for a new cycle. It does so only when one of its slot levels differs from the level it last reported. Slot 3 is shared: it carries interrupt 2 or a system-management request, and the management request takes part only while its frame enable is set.

Top module: `sirq_agent`

## Requirements
- R1: While `rst` is high, `drive_en` is low from the first clock edge that samples reset. The agent leaves reset idle in continuous mode, so it makes no request until a closing pulse of 2 clocks has been seen.
- R2: A cycle starts only when the line is sampled low on 4 to 8 consecutive edges and then sampled high. Slot 1's sample clock is the clock right after the edge that first samples high. Low runs of 1 to 3 clocks, or of 9 clocks or more, start nothing.
- R3: Slot p (counted from 1) carries `irq_n[p-1]`, which is active low. In the slot's sample clock, an active input gives `drive_en`=1 with `drive_low`=1, and an inactive input gives both 0.
- R4: In the clock after its own low sample clock, the agent drives the line high (`drive_en`=1, `drive_low`=0). In the third clock of every slot both outputs are 0. A slot that was not driven low is never driven high.
- R5: Slot 3 is active when `irq_n[2]` is 0, or when `smi_n` is 0 and `smi_frame_en` is 1. With `smi_frame_en` at 0, `smi_n` has no effect.
- R6: Slot 14 carries `irq_n[13]`.
- R7: A cycle has exactly `NUM_FRAMES` slots (17 by default). After the last slot the agent drives nothing until the next start.
- R8: A closing low pulse of 2 clocks selects quiet mode and one of 3 clocks selects continuous mode. Any other width leaves the mode unchanged.
- R9: In quiet mode the agent drives one clock low (`drive_en`=1, `drive_low`=1), and only when three conditions hold: a slot level differs from the value it reported in the last cycle, the line is sampled high, and it is at least the second clock after the edge that first samples the line high following the closing pulse.
- R10: In continuous mode the agent never drives the line outside the slots.
- R11: The agent makes at most one request per cycle. It can request again only after a new start has been detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rst | input | 1 | Bus reset, synchronous, active high |
| line_in | input | 1 | Sampled level of the shared interrupt line |
| irq_n | input | NUM_FRAMES | Local interrupt levels, active low, bit i reported in slot i+1 |
| smi_n | input | 1 | Management request, active low, shares slot 3 |
| smi_frame_en | input | 1 | Allows `smi_n` onto slot 3 |
| drive_en | output | 1 | Output enable for the line driver |
| drive_low | output | 1 | With `drive_en` set, 1 pulls the line low and 0 drives it high |

## Verification
The bench sweeps the start pulse width from 1 to 10 clocks. It catches an agent whose start window is off by one: such an agent either answers a 3- or 9-clock pulse or misses a 4- or 8-clock one. Fixed input patterns target slots 1, 3, 14 and 17, so a slot mapped one place off or a cycle with the wrong length shows up as a drive in the wrong clock. Closing pulses of 1, 2, 3 and 4 clocks check that only 2 and 3 change the mode. The quiet-mode tests place an input change at three moments: during the closing pulse, long after it, and never. They catch a request on the first idle clock, a request with nothing changed, a repeated request, and a request in continuous mode. A reset in the middle of a slot must release the line at once and return the agent to continuous mode.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;

    // start pulse window and closing pulse widths, in bus clocks
    localparam int unsigned START_MIN  = 4;
    localparam int unsigned START_MAX  = 8;
    localparam int unsigned STOP_QUIET = 2;
    localparam int unsigned STOP_CONT  = 3;

    // interrupt number whose slot is shared with the management request
    localparam int unsigned SHARED_IRQ = 2;

    // low-run counter must reach beyond START_MAX to reject long pulses
    localparam int unsigned RUN_CNT_W = $clog2(START_MAX + 2);

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FRAMES = 2'd1,
        SEQ_STOP   = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE  = 2'd0,
        PH_RECOVER = 2'd1,
        PH_TURN    = 2'd2
    } phase_e;

    typedef enum logic {
        MODE_CONT  = 1'b0,
        MODE_QUIET = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic en;
        logic low;
    } drive_t;

    function automatic drive_t drive_off();
        drive_t d;
        d.en  = 1'b0;
        d.low = 1'b0;
        return d;
    endfunction

    function automatic drive_t drive_pull(input logic active);
        drive_t d;
        d.en  = active;
        d.low = active;
        return d;
    endfunction

    function automatic logic is_start_width(input int unsigned w);
        return (w >= START_MIN) && (w <= START_MAX);
    endfunction

endpackage

// File: rtl/sirq_line_mon.sv
`timescale 1ns/1ps
module sirq_line_mon
    import sirq_pkg::*;
#(
    parameter int unsigned CNT_W = RUN_CNT_W
)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    output logic             mon_rise,
    output logic [CNT_W-1:0] mon_width
);

    logic [CNT_W-1:0] run_q;

    // consecutive low samples, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (line_in) begin
            run_q <= '0;
        end else if (run_q != {CNT_W{1'b1}}) begin
            run_q <= run_q + CNT_W'(1);
        end
    end

    assign mon_rise  = line_in && (run_q != '0);
    assign mon_width = run_q;

endmodule

// File: rtl/sirq_slot_map.sv
`timescale 1ns/1ps
module sirq_slot_map
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 17
)
(
    input  logic [NUM_FRAMES-1:0] irq_n,
    input  logic                  smi_n,
    input  logic                  smi_frame_en,
    output logic [NUM_FRAMES-1:0] slot_active
);

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_slot
        if (i == SHARED_IRQ) begin : g_shared
            assign slot_active[i] = !irq_n[i] || (!smi_n && smi_frame_en);
        end else begin : g_plain
            assign slot_active[i] = !irq_n[i];
        end
    end

endmodule

// File: rtl/sirq_quiet_req.sv
`timescale 1ns/1ps
module sirq_quiet_req
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 17,
    parameter int unsigned IDX_W      = $clog2(NUM_FRAMES)
)
(
    input  logic                  clk,
    input  logic                  rst,
    input  seq_state_e            seq_state,
    input  bus_mode_e             bus_mode,
    input  logic                  line_in,
    input  logic                  start_evt,
    input  logic [NUM_FRAMES-1:0] slot_active,
    input  logic                  report_we,
    input  logic [IDX_W-1:0]      report_idx,
    output logic                  req_fire
);

    logic [NUM_FRAMES-1:0] reported_q;
    logic                  done_q;
    logic                  changed;

    assign changed  = (slot_active != reported_q);
    assign req_fire = (seq_state == SEQ_IDLE) && (bus_mode == MODE_QUIET)
                   && line_in && !start_evt && !done_q && changed;

    always_ff @(posedge clk) begin
        if (rst) begin
            reported_q <= '0;
            done_q     <= 1'b0;
        end else begin
            if (start_evt) begin
                done_q <= 1'b0;
            end else if (req_fire) begin
                done_q <= 1'b1;
            end
            if (report_we) begin
                reported_q[report_idx] <= slot_active[report_idx];
            end
        end
    end

endmodule

// File: rtl/sirq_frame_seq.sv
`timescale 1ns/1ps
module sirq_frame_seq
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 17,
    parameter int unsigned IDX_W      = $clog2(NUM_FRAMES),
    parameter int unsigned CNT_W      = RUN_CNT_W
)
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mon_rise,
    input  logic [CNT_W-1:0]      mon_width,
    input  logic [NUM_FRAMES-1:0] slot_active,
    input  logic                  req_fire,
    output seq_state_e            seq_state,
    output phase_e                seq_phase,
    output bus_mode_e             bus_mode,
    output logic                  start_evt,
    output logic                  report_we,
    output logic [IDX_W-1:0]      report_idx,
    output drive_t                drive
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    seq_state_e       state_q;
    phase_e           phase_q;
    bus_mode_e        mode_q;
    logic [IDX_W-1:0] idx_q;
    logic             own_q;
    drive_t           drv_q;

    logic             advance;
    logic [IDX_W-1:0] next_idx;
    logic             next_own;

    assign start_evt = (state_q == SEQ_IDLE) && mon_rise
                    && is_start_width(32'(mon_width));
    assign advance   = (state_q == SEQ_FRAMES) && (phase_q == PH_TURN)
                    && (idx_q != LAST_IDX);
    assign next_idx  = start_evt ? '0 : idx_q + IDX_W'(1);
    assign next_own  = slot_active[next_idx];

    assign report_we  = start_evt || advance;
    assign report_idx = next_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            phase_q <= PH_SAMPLE;
            mode_q  <= MODE_CONT;
            idx_q   <= '0;
            own_q   <= 1'b0;
            drv_q   <= drive_off();
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_evt) begin
                        state_q <= SEQ_FRAMES;
                        phase_q <= PH_SAMPLE;
                        idx_q   <= next_idx;
                        own_q   <= next_own;
                        drv_q   <= drive_pull(next_own);
                    end else if (req_fire) begin
                        drv_q   <= drive_pull(1'b1);
                    end else begin
                        drv_q   <= drive_off();
                    end
                end
                SEQ_FRAMES: begin
                    case (phase_q)
                        PH_SAMPLE: begin
                            phase_q   <= PH_RECOVER;
                            drv_q.en  <= own_q;
                            drv_q.low <= 1'b0;
                        end
                        PH_RECOVER: begin
                            phase_q <= PH_TURN;
                            drv_q   <= drive_off();
                        end
                        default: begin
                            if (advance) begin
                                phase_q <= PH_SAMPLE;
                                idx_q   <= next_idx;
                                own_q   <= next_own;
                                drv_q   <= drive_pull(next_own);
                            end else begin
                                state_q <= SEQ_STOP;
                                phase_q <= PH_SAMPLE;
                                drv_q   <= drive_off();
                            end
                        end
                    endcase
                end
                default: begin
                    drv_q <= drive_off();
                    if (mon_rise) begin
                        state_q <= SEQ_IDLE;
                        if (mon_width == CNT_W'(STOP_QUIET)) begin
                            mode_q <= MODE_QUIET;
                        end else if (mon_width == CNT_W'(STOP_CONT)) begin
                            mode_q <= MODE_CONT;
                        end
                    end
                end
            endcase
        end
    end

    assign seq_state = state_q;
    assign seq_phase = phase_q;
    assign bus_mode  = mode_q;
    assign drive     = drv_q;

endmodule

// File: rtl/sirq_agent.sv
`timescale 1ns/1ps
module sirq_agent
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 17
)
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_in,
    input  logic [NUM_FRAMES-1:0] irq_n,
    input  logic                  smi_n,
    input  logic                  smi_frame_en,
    output logic                  drive_en,
    output logic                  drive_low
);

    localparam int unsigned IDX_W = $clog2(NUM_FRAMES);
    localparam int unsigned CNT_W = RUN_CNT_W;

    logic                  mon_rise;
    logic [CNT_W-1:0]      mon_width;
    logic [NUM_FRAMES-1:0] slot_active;
    logic                  req_fire;
    seq_state_e            seq_state;
    phase_e                seq_phase;
    bus_mode_e             bus_mode;
    logic                  start_evt;
    logic                  report_we;
    logic [IDX_W-1:0]      report_idx;
    drive_t                drive;

    sirq_line_mon #(.CNT_W(CNT_W)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .mon_rise  (mon_rise),
        .mon_width (mon_width)
    );

    sirq_slot_map #(.NUM_FRAMES(NUM_FRAMES)) u_map (
        .irq_n        (irq_n),
        .smi_n        (smi_n),
        .smi_frame_en (smi_frame_en),
        .slot_active  (slot_active)
    );

    sirq_frame_seq #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .mon_rise    (mon_rise),
        .mon_width   (mon_width),
        .slot_active (slot_active),
        .req_fire    (req_fire),
        .seq_state   (seq_state),
        .seq_phase   (seq_phase),
        .bus_mode    (bus_mode),
        .start_evt   (start_evt),
        .report_we   (report_we),
        .report_idx  (report_idx),
        .drive       (drive)
    );

    sirq_quiet_req #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_req (
        .clk         (clk),
        .rst         (rst),
        .seq_state   (seq_state),
        .bus_mode    (bus_mode),
        .line_in     (line_in),
        .start_evt   (start_evt),
        .slot_active (slot_active),
        .report_we   (report_we),
        .report_idx  (report_idx),
        .req_fire    (req_fire)
    );

    assign drive_en  = drive.en;
    assign drive_low = drive.low;

endmodule

// File: rtl/sirq_agent_chk.sv
`timescale 1ns/1ps
module sirq_agent_chk
    import sirq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 drive_en,
    input logic                 drive_low,
    input seq_state_e           seq_state,
    input phase_e               seq_phase,
    input bus_mode_e            bus_mode,
    input logic                 start_evt,
    input logic                 mon_rise,
    input logic [RUN_CNT_W-1:0] mon_width
);

    assert_reset_release_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!drive_en && bus_mode == MODE_CONT));

    assert_start_enters_slots_R2: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (seq_state == SEQ_FRAMES && seq_phase == PH_SAMPLE));

    assert_low_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        drive_low |-> drive_en);

    assert_recover_high_R4: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_FRAMES && seq_phase == PH_SAMPLE && drive_en)
        |=> (drive_en && !drive_low));

    assert_recover_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_FRAMES && seq_phase == PH_SAMPLE && !drive_en)
        |=> !drive_en);

    assert_turn_release_R4: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_FRAMES && seq_phase == PH_RECOVER) |=> !drive_en);

    assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_STOP && mon_rise && mon_width == RUN_CNT_W'(STOP_QUIET))
        |=> bus_mode == MODE_QUIET);

    assert_stop_cont_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_STOP && mon_rise && mon_width == RUN_CNT_W'(STOP_CONT))
        |=> bus_mode == MODE_CONT);

    assert_cont_silent_R10: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_IDLE && bus_mode == MODE_CONT) |-> !drive_en);

    assert_single_request_R11: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SEQ_IDLE && drive_en) |=> !drive_en);

endmodule

bind sirq_agent sirq_agent_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .drive_en  (drive_en),
    .drive_low (drive_low),
    .seq_state (seq_state),
    .seq_phase (seq_phase),
    .bus_mode  (bus_mode),
    .start_evt (start_evt),
    .mon_rise  (mon_rise),
    .mon_width (mon_width)
);

// File: tb/sirq_agent_bench.sv
`timescale 1ns/1ps
module sirq_agent_bench;

    localparam int NF = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_low = 1'b0;
    logic [NF-1:0] irq_n = '1;
    logic          smi_n = 1'b1;
    logic          smi_frame_en = 1'b0;
    logic          drive_en;
    logic          drive_low;
    logic          line_in;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // wired-AND line: released level is high
    assign line_in = !(host_low || (drive_en && drive_low));

    always #2.5 clk = ~clk;

    sirq_agent #(.NUM_FRAMES(NF)) u_sirq_agent (
        .clk          (clk),
        .rst          (rst),
        .line_in      (line_in),
        .irq_n        (irq_n),
        .smi_n        (smi_n),
        .smi_frame_en (smi_frame_en),
        .drive_en     (drive_en),
        .drive_low    (drive_low)
    );

    task automatic expect_drive(input string tag, input logic en_e, input logic low_e);
        checks++;
        if (drive_en !== en_e || drive_low !== low_e) begin
            errors++;
            $display("FAIL %s: drive_en,drive_low=%b%b expected %b%b at %0t",
                     tag, drive_en, drive_low, en_e, low_e, $time);
        end
    endtask

    function automatic logic exp_active(input int p);
        return !irq_n[p] || (p == 2 && !smi_n && smi_frame_en);
    endfunction

    function automatic string slot_tag(input int p);
        if (p == 2)  return "R5";
        if (p == 13) return "R6";
        return "R3";
    endfunction

    function automatic logic [NF-1:0] sweep_pattern(input int w);
        logic [NF-1:0] v;
        case (w)
            4:       v = '0;
            5:       for (int i = 0; i < NF; i++) v[i] = i[0];
            6:       v = ~(NF'(1) << 13);
            7:       v = ~(NF'(1) << 2);
            default: v = ~(NF'(1) << (NF - 1));
        endcase
        return v;
    endfunction

    task automatic idle_check(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            expect_drive(tag, 1'b0, 1'b0);
        end
    endtask

    task automatic host_pulse(input int w);
        @(negedge clk);
        host_low = 1'b1;
        repeat (w) @(negedge clk);
        host_low = 1'b0;
    endtask

    // host extends a start already begun by the agent's request
    task automatic host_extend(input int w);
        host_low = 1'b1;
        repeat (w) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic expect_slots();
        for (int p = 0; p < NF; p++) begin
            logic a;
            a = exp_active(p);
            @(negedge clk);
            expect_drive(slot_tag(p), a, a);
            @(negedge clk);
            expect_drive("R4", a, 1'b0);
            @(negedge clk);
            expect_drive("R4", 1'b0, 1'b0);
        end
    endtask

    task automatic host_stop(input int w);
        @(negedge clk);
        expect_drive("R7", 1'b0, 1'b0);
        host_low = 1'b1;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            expect_drive("R7", 1'b0, 1'b0);
        end
        host_low = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        // R1: reset releases the line even with active inputs
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            irq_n = '0;
            expect_drive("R1", 1'b0, 1'b0);
        end
        rst = 1'b0;
        idle_check(4, "R1");
        irq_n = '1;
        idle_check(6, "R1");

        // R2: sweep start widths, valid ones carry a slot pattern
        for (int w = 1; w <= 10; w++) begin
            if (w >= 4 && w <= 8) begin
                irq_n = sweep_pattern(w);
                host_pulse(w);
                expect_slots();
                host_stop(3);
                irq_n = ~irq_n;
                idle_check(3, "R10");
            end else begin
                irq_n = '0;
                host_pulse(w);
                idle_check(3 * NF, "R2");
            end
        end

        // R5: shared slot under each enable combination
        irq_n = '1; smi_n = 1'b0; smi_frame_en = 1'b0;
        host_pulse(5); expect_slots(); host_stop(3);
        smi_frame_en = 1'b1;
        host_pulse(6); expect_slots(); host_stop(3);
        smi_n = 1'b1; irq_n = ~(NF'(1) << 2); smi_frame_en = 1'b0;
        host_pulse(4); expect_slots(); host_stop(3);

        // R8: width 1 keeps continuous mode
        irq_n = '1;
        host_pulse(4); expect_slots(); host_stop(1);
        irq_n = ~(NF'(1) << 5);
        idle_check(10, "R8");

        // R9: quiet mode without a change stays silent
        host_pulse(4); expect_slots(); host_stop(2);
        idle_check(20, "R9");

        // R9/R11: change long after stop gives one request, host ignores it
        @(negedge clk);
        irq_n = ~(NF'(1) << 9);
        @(negedge clk);
        expect_drive("R9", 1'b1, 1'b1);
        idle_check(12, "R11");

        // quiet mode, host-opened cycle, change during the stop pulse
        host_pulse(5); expect_slots();
        irq_n = ~(NF'(1) << 0);
        host_stop(2);
        @(negedge clk);
        expect_drive("R9", 1'b0, 1'b0);
        @(negedge clk);
        expect_drive("R9", 1'b1, 1'b1);
        host_extend(4);
        expect_slots();
        host_stop(4);

        // R8: width 4 keeps quiet mode
        @(negedge clk);
        irq_n = ~(NF'(1) << 16);
        @(negedge clk);
        expect_drive("R8", 1'b1, 1'b1);
        host_extend(4);
        expect_slots();
        host_stop(3);

        // R10: continuous mode, change gives no request
        irq_n = '1;
        idle_check(15, "R10");

        // R1: reset inside a slot from quiet mode
        irq_n = '0;
        host_pulse(4); expect_slots(); host_stop(2);
        idle_check(3, "R9");
        host_pulse(4);
        @(negedge clk);
        expect_drive("R3", 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        expect_drive("R1", 1'b0, 1'b0);
        @(negedge clk);
        expect_drive("R1", 1'b0, 1'b0);
        rst = 1'b0;
        irq_n = '1;
        idle_check(10, "R1");

        done = 1'b1;
        finish_run();
    end

endmodule